// File: doc/BRIEF.md
# Display Controller Power-Up Command Sequencer

This block brings up a display controller that listens on a write-only SPI link. When reset is released it reads a fixed command table built into the design. The table holds groups of command bytes, and each group starts with its byte count. The block sends each group inside its own chip-select frame, with the data/command line held in command mode. A zero count marks the end of the table. At that point the done flag rises.

After bring-up, the host can change the panel contrast at any time. It does this by pulsing a request together with a new 8-bit value. The block remembers the most recent request. It sends the request as its own three-byte command group at the next group boundary, which may fall in the middle of bring-up. The stored contrast value changes only when that group has fully left the wire. On the link, every real byte is followed by a 0xFF filler byte. The serial clock comes from the system clock through a divider set by a parameter, and the clock polarity and phase are also set by parameters.

Top module: `oled_init_seq`

## Requirements
- R1: The table is read as entries. Each entry is a count byte followed by that many command bytes. Each entry is sent as one frame in which `cs_n` stays low, with its bytes in table order. A count of zero stops the walk.
- R2: In every frame, each real byte is followed at once by one 0xFF filler byte, before the next real byte or the end of the frame.
- R3: Each byte is 8 bits, most significant bit first. `sclk` idles at level CPOL whenever no frame is open. With CPHA=0, `mosi` is valid at the leading edge of `sclk`. With CPHA=1, it is valid at the trailing edge.
- R4: The bring-up frames, in this order, are:
  - FD 12 E3 (unlock)
  - AE E3 (sleep)
  - A8 5F E3
  - 81 B7 E3
  - B1 11 E3
  - B2 23 E3
  - B3 E2 E3 (divide ratio 3 stored as 2 in bits [3:0], oscillator setting 14 in bits [7:4])
  - B8, then 1 2 3 4 5 6 8 10 12 14 16 19 22 26 30, then E3
  - AF E3 (wake)
- R5: `dc` stays low (command mode) at all times.
- R6: Between two frames, `cs_n` stays high for at least one `sclk` period, which is 2*HALF_DIV clock cycles.
- R7: Reset sets `contrast` to 183 (0xB7).
- R8: A contrast request sends the frame 81, value, E3. `contrast` keeps its old value while that frame is on the wire. It takes the new value in the same cycle that `cs_n` rises at the end of the frame. It changes at no other time.
- R9: A request that arrives while a frame or gap is running is held. It is sent before the next table frame. If several requests arrive before it is sent, only the last value goes out, as a single frame.
- R10: `done` rises after the zero count has been read and stays high until reset. `busy` is high whenever a frame is open and is low once the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctr_req | input | 1 | One-cycle contrast update request |
| ctr_val | input | 8 | New contrast value, sampled together with `ctr_req` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the panel |
| cs_n | output | 1 | Active-low chip select, one frame per command group |
| dc | output | 1 | Data/command select, low for commands |
| contrast | output | 8 | Current contrast value |
| busy | output | 1 | Sequencer is sending or waiting between frames |
| done | output | 1 | Bring-up table finished |

## Verification
The bench builds the block with HALF_DIV=2, CPOL=1 and CPHA=0. This keeps the whole 39-byte bring-up plus its fillers within a few thousand cycles, and it places the sampling edge on the falling edge of `sclk`. The short divider gives a minimum inter-frame gap of four cycles, so the R6 bound is tight enough that an off-by-one in the gap counter becomes visible. With a bring-up frame lasting about two hundred cycles, two contrast requests can be placed inside the first frame. This exercises the case where the request is held, overwritten by a later value, and then sent ahead of the rest of the table.

// File: rtl/oseq_pkg.sv
package oseq_pkg;

  localparam int ROM_AW = 6;

  localparam logic [7:0] OP_UNLOCK   = 8'hFD;
  localparam logic [7:0] KEY_OPEN    = 8'h12;
  localparam logic [7:0] OP_SLEEP    = 8'hAE;
  localparam logic [7:0] OP_WAKE     = 8'hAF;
  localparam logic [7:0] OP_MUX      = 8'hA8;
  localparam logic [7:0] OP_CONTRAST = 8'h81;
  localparam logic [7:0] OP_PHASE    = 8'hB1;
  localparam logic [7:0] OP_ROWCLK   = 8'hB2;
  localparam logic [7:0] OP_CLKDIV   = 8'hB3;
  localparam logic [7:0] OP_GRAY     = 8'hB8;
  localparam logic [7:0] OP_NOP      = 8'hE3;
  localparam logic [7:0] FILL_BYTE   = 8'hFF;

  // First and last table index of the gray-scale widths
  localparam int GRAY_LO = 29;
  localparam int GRAY_HI = 43;

  typedef enum logic [3:0] {
    S_PICK, S_FETCH, S_OPEN, S_REAL, S_WREAL, S_FILL, S_WFILL, S_GAP, S_IDLE
  } seq_state_t;

  // Divider argument: oscillator code high nibble, ratio-1 low nibble
  function automatic logic [7:0] clkdiv_arg(int ratio, int osc);
    return 8'(((osc & 15) << 4) | ((ratio - 1) & 15));
  endfunction

  // Minimum chip-select high time: one full serial clock period
  function automatic int gap_cycles(int half_div);
    return 2 * half_div;
  endfunction

  function automatic logic [7:0] gray_width(int k);
    case (k)
      0: return 8'd1;   1: return 8'd2;   2: return 8'd3;   3: return 8'd4;
      4: return 8'd5;   5: return 8'd6;   6: return 8'd8;   7: return 8'd10;
      8: return 8'd12;  9: return 8'd14;  10: return 8'd16; 11: return 8'd19;
      12: return 8'd22; 13: return 8'd26; 14: return 8'd30;
      default: return 8'd0;
    endcase
  endfunction

  // Bring-up table: count byte, then payload; zero count ends it
  function automatic logic [7:0] rom_byte(logic [ROM_AW-1:0] a, logic [7:0] ctr0);
    int ai;
    ai = int'(a);
    if (ai >= GRAY_LO && ai <= GRAY_HI) return gray_width(ai - GRAY_LO);
    case (ai)
      0:  return 8'd3;  1: return OP_UNLOCK;   2: return KEY_OPEN;  3: return OP_NOP;
      4:  return 8'd2;  5: return OP_SLEEP;    6: return OP_NOP;
      7:  return 8'd3;  8: return OP_MUX;      9: return 8'd95;     10: return OP_NOP;
      11: return 8'd3; 12: return OP_CONTRAST; 13: return ctr0;    14: return OP_NOP;
      15: return 8'd3; 16: return OP_PHASE;    17: return 8'h11;   18: return OP_NOP;
      19: return 8'd3; 20: return OP_ROWCLK;   21: return 8'd35;   22: return OP_NOP;
      23: return 8'd3; 24: return OP_CLKDIV;   25: return clkdiv_arg(3, 14);
      26: return OP_NOP;
      27: return 8'd17; 28: return OP_GRAY;    44: return OP_NOP;
      45: return 8'd2; 46: return OP_WAKE;     47: return OP_NOP;
      default: return 8'd0;
    endcase
  endfunction

  // Runtime contrast frame: opcode, value, no-op
  function automatic logic [7:0] ctr_group_byte(logic [1:0] idx, logic [7:0] v);
    case (idx)
      2'd0: return OP_CONTRAST;
      2'd1: return v;
      default: return OP_NOP;
    endcase
  endfunction

endpackage

// File: rtl/seq_rom.sv
module seq_rom
  import oseq_pkg::*;
#(
  parameter logic [7:0] CONTRAST_RST = 8'd183
) (
  input  logic [ROM_AW-1:0] addr,
  output logic [7:0]        data
);

  always_comb data = rom_byte(addr, CONTRAST_RST);

endmodule

// File: rtl/spi_shift_tx.sv
module spi_shift_tx #(
  parameter int HALF_DIV = 4,
  parameter int CPOL     = 1,
  parameter int CPHA     = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] din,
  output logic       sclk,
  output logic       mosi,
  output logic       active,
  output logic       done
);

  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam logic IDLE_LVL = 1'(CPOL);

  logic [DIV_W-1:0] div_q;
  logic [3:0]       half_q;
  logic [7:0]       sreg_q;
  logic             tick;
  logic             shift_now;

  assign tick = active && (div_q == DIV_W'(HALF_DIV - 1));

  // Choose the edge on which the next bit is presented
  generate
    if (CPHA == 0) begin : g_pha0
      assign shift_now = tick && half_q[0];
    end else begin : g_pha1
      assign shift_now = tick && !half_q[0] && (half_q != 4'd0);
    end
  endgenerate

  assign mosi = sreg_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      div_q  <= '0;
      half_q <= '0;
      sreg_q <= 8'hFF;
      sclk   <= IDLE_LVL;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        sreg_q <= din;
        half_q <= '0;
        div_q  <= '0;
        sclk   <= IDLE_LVL;
      end else if (active) begin
        if (tick) begin
          div_q  <= '0;
          sclk   <= ~sclk;
          half_q <= half_q + 4'd1;
          if (shift_now) sreg_q <= {sreg_q[6:0], 1'b1};
          if (half_q == 4'd15) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end else begin
          div_q <= div_q + DIV_W'(1);
        end
      end
    end
  end

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> sclk == IDLE_LVL);

  assert_start_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import oseq_pkg::*;
#(
  parameter int         HALF_DIV     = 4,
  parameter logic [7:0] CONTRAST_RST = 8'd183
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rom_data,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              tx_start,
  output logic [7:0]        tx_byte,
  input  logic              tx_done,
  input  logic              req,
  input  logic [7:0]        req_val,
  output logic              cs_n,
  output logic              busy,
  output logic              done,
  output logic [7:0]        contrast
);

  localparam int GAP   = gap_cycles(HALF_DIV);
  localparam int GAP_W = $clog2(GAP + 1);

  seq_state_t        state;
  logic [ROM_AW-1:0] ptr;
  logic [7:0]        remain;
  logic              from_ctr;
  logic [1:0]        cidx;
  logic [GAP_W-1:0]  gapcnt;
  logic              pend;
  logic [7:0]        pend_val;
  logic [7:0]        cur_val;

  // Named events for the checks below
  logic group_end;
  logic table_end;
  assign group_end = (state == S_WFILL) && tx_done && (remain == 8'd1);
  assign table_end = (state == S_FETCH) && (rom_data == 8'd0);

  assign rom_addr = ptr;
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_PICK;
      ptr      <= '0;
      remain   <= '0;
      from_ctr <= 1'b0;
      cidx     <= '0;
      gapcnt   <= '0;
      pend     <= 1'b0;
      pend_val <= '0;
      cur_val  <= '0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      contrast <= CONTRAST_RST;
      tx_start <= 1'b0;
      tx_byte  <= FILL_BYTE;
    end else begin
      tx_start <= 1'b0;
      case (state)
        S_PICK: begin
          if (pend) begin
            pend     <= 1'b0;
            cur_val  <= pend_val;
            from_ctr <= 1'b1;
            cidx     <= '0;
            remain   <= 8'd3;
            state    <= S_OPEN;
          end else if (!done) begin
            state <= S_FETCH;
          end else begin
            state <= S_IDLE;
          end
        end
        S_FETCH: begin
          if (table_end) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            remain   <= rom_data;
            from_ctr <= 1'b0;
            ptr      <= ptr + ROM_AW'(1);
            state    <= S_OPEN;
          end
        end
        S_OPEN: begin
          cs_n  <= 1'b0;
          state <= S_REAL;
        end
        S_REAL: begin
          tx_start <= 1'b1;
          if (from_ctr) begin
            tx_byte <= ctr_group_byte(cidx, cur_val);
            cidx    <= cidx + 2'd1;
          end else begin
            tx_byte <= rom_data;
            ptr     <= ptr + ROM_AW'(1);
          end
          state <= S_WREAL;
        end
        S_WREAL: if (tx_done) state <= S_FILL;
        S_FILL: begin
          tx_start <= 1'b1;
          tx_byte  <= FILL_BYTE;
          state    <= S_WFILL;
        end
        S_WFILL: begin
          if (tx_done) begin
            remain <= remain - 8'd1;
            if (group_end) begin
              cs_n   <= 1'b1;
              gapcnt <= '0;
              if (from_ctr) contrast <= cur_val;
              state  <= S_GAP;
            end else begin
              state <= S_REAL;
            end
          end
        end
        S_GAP: begin
          gapcnt <= gapcnt + GAP_W'(1);
          if (gapcnt == GAP_W'(GAP - 1)) state <= S_PICK;
        end
        S_IDLE: if (pend) state <= S_PICK;
        default: state <= S_PICK;
      endcase
      // A new request overrides any older pending value
      if (req) begin
        pend     <= 1'b1;
        pend_val <= req_val;
      end
    end
  end

  // Checker: count cycles with chip select released
  logic [GAP_W-1:0] gap_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap_seen <= GAP_W'(GAP);
    else if (cs_n) gap_seen <= (gap_seen < GAP_W'(GAP)) ? gap_seen + GAP_W'(1) : gap_seen;
    else           gap_seen <= '0;
  end

  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> gap_seen >= GAP_W'(GAP));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_busy_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_group_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    group_end |=> cs_n);

endmodule

// File: rtl/oled_init_seq.sv
module oled_init_seq
  import oseq_pkg::*;
#(
  parameter int         HALF_DIV     = 4,
  parameter int         CPOL         = 1,
  parameter int         CPHA         = 0,
  parameter logic [7:0] CONTRAST_RST = 8'd183
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctr_req,
  input  logic [7:0] ctr_val,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n,
  output logic       dc,
  output logic [7:0] contrast,
  output logic       busy,
  output logic       done
);

  logic [ROM_AW-1:0] rom_addr;
  logic [7:0]        rom_data;
  logic              tx_start;
  logic [7:0]        tx_byte;
  logic              tx_done;
  logic              tx_active;

  // Only command groups are produced, so the select stays in command mode
  assign dc = 1'b0;

  seq_rom #(.CONTRAST_RST(CONTRAST_RST)) u_rom (
    .addr (rom_addr),
    .data (rom_data)
  );

  seq_ctrl #(.HALF_DIV(HALF_DIV), .CONTRAST_RST(CONTRAST_RST)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rom_data (rom_data),
    .rom_addr (rom_addr),
    .tx_start (tx_start),
    .tx_byte  (tx_byte),
    .tx_done  (tx_done),
    .req      (ctr_req),
    .req_val  (ctr_val),
    .cs_n     (cs_n),
    .busy     (busy),
    .done     (done),
    .contrast (contrast)
  );

  spi_shift_tx #(.HALF_DIV(HALF_DIV), .CPOL(CPOL), .CPHA(CPHA)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tx_start),
    .din    (tx_byte),
    .sclk   (sclk),
    .mosi   (mosi),
    .active (tx_active),
    .done   (tx_done)
  );

  assert_shift_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> !cs_n);

  assert_ctr_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(contrast) |-> $rose(cs_n));

endmodule

// File: tb/oled_init_seq_test.sv
`timescale 1ns/100ps
module oled_init_seq_test;

  localparam int HALF = 2;
  localparam int POL  = 1;
  localparam int PHA  = 0;
  localparam logic SAMPLE_LVL = (PHA == 0) ? !1'(POL) : 1'(POL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [7:0] val = 8'd0;
  logic sclk, mosi, cs_n, dc, busy, done;
  logic [7:0] contrast;

  always #2.5 clk = ~clk;

  oled_init_seq #(.HALF_DIV(HALF), .CPOL(POL), .CPHA(PHA), .CONTRAST_RST(8'd183)) uut (
    .clk(clk), .rst_n(rst_n), .ctr_req(req), .ctr_val(val),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .dc(dc),
    .contrast(contrast), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int obs[$];
  int exp_q[$];
  string tags[$];
  int nbits = 0;
  logic [7:0] acc = 8'd0;

  task automatic chk(input bit ok, input string r, input string what, input int a, input int e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, a, e);
    end
  endtask

  // Wire capture: bits on the sampling edge, frames on chip-select release (R3)
  always @(sclk) begin
    if (rst_n && !cs_n && sclk == SAMPLE_LVL) begin
      acc = {acc[6:0], mosi};
      nbits++;
      if (nbits == 8) begin
        obs.push_back(int'(acc));
        nbits = 0;
      end
    end
  end

  always @(posedge cs_n) begin
    if (rst_n) begin
      chk(nbits == 0, "R3", "whole bytes per frame", nbits, 0);
      nbits = 0;
      obs.push_back(-1);
    end
  end

  // Clock-by-clock reference checks
  logic prev_done = 1'b0;
  logic prev_cs = 1'b1;
  logic [7:0] prev_ctr = 8'd183;
  int gap = 1000;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_done = 1'b0; prev_cs = 1'b1; prev_ctr = contrast; gap = 1000;
    end else begin
      chk(dc == 1'b0, "R5", "dc in command mode", dc, 0);
      if (cs_n) chk(sclk == 1'(POL), "R3", "sclk idle level", sclk, POL);
      else      chk(busy == 1'b1, "R10", "busy while framed", busy, 1);
      chk(!(prev_done && !done), "R10", "done sticky", done, 1);
      if (contrast != prev_ctr)
        chk(cs_n && !prev_cs, "R8", "contrast moves only at frame end", contrast, prev_ctr);
      if (cs_n) gap++;
      else begin
        if (prev_cs) chk(gap >= 2 * HALF, "R6", "cs_n high gap", gap, 2 * HALF);
        gap = 0;
      end
      prev_done = done; prev_cs = cs_n; prev_ctr = contrast;
    end
  end

  task automatic put(input int b);
    exp_q.push_back(b);
    exp_q.push_back(8'hFF);
  endtask

  task automatic close(input string t);
    exp_q.push_back(-1);
    tags.push_back(t);
  endtask

  task automatic ctr_frame(input int v);
    put(8'h81); put(v); put(8'hE3); close("R8 R9 contrast frame");
  endtask

  task automatic table_after_first();
    int gw[15] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 14, 16, 19, 22, 26, 30};
    put(8'hAE); put(8'hE3); close("R4 sleep");
    put(8'hA8); put(95); put(8'hE3); close("R1 mux");
    put(8'h81); put(183); put(8'hE3); close("R1 contrast default");
    put(8'hB1); put(8'h11); put(8'hE3); close("R4 phase");
    put(8'hB2); put(35); put(8'hE3); close("R4 row period");
    put(8'hB3); put((14 << 4) | (3 - 1)); put(8'hE3); close("R4 clock divider");
    put(8'hB8);
    foreach (gw[i]) put(gw[i]);
    put(8'hE3); close("R4 gray table");
    put(8'hAF); put(8'hE3); close("R4 wake");
  endtask

  task automatic first_frame();
    put(8'hFD); put(8'h12); put(8'hE3); close("R4 unlock");
  endtask

  task automatic match_groups();
    int oi = 0;
    int ei = 0;
    while (ei < exp_q.size()) begin
      int eg[$];
      int og[$];
      string t;
      int da, de, a, e, n;
      eg.delete(); og.delete();
      t = tags.pop_front();
      while (exp_q[ei] != -1) begin eg.push_back(exp_q[ei]); ei++; end
      ei++;
      while (oi < obs.size() && obs[oi] != -1) begin og.push_back(obs[oi]); oi++; end
      oi++;
      da = -2; de = -2;
      n = (eg.size() > og.size()) ? eg.size() : og.size();
      for (int k = 0; k < n; k++) begin
        a = (k < og.size()) ? og[k] : -1;
        e = (k < eg.size()) ? eg[k] : -1;
        if (a != e && da == -2) begin da = a; de = e; end
      end
      chk(da == -2, {t, " R1 R2 bytes"}, "first differing byte", da, de);
    end
    chk(oi == obs.size(), "R1", "frame count", obs.size(), oi);
    obs.delete(); exp_q.delete(); tags.delete();
  endtask

  task automatic pulse_req(input logic [7:0] v);
    @(negedge clk); req = 1'b1; val = v;
    @(negedge clk); req = 1'b0;
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
    chk(contrast == 8'd183, "R7", "contrast reset", contrast, 183);
    chk(done == 1'b0, "R10", "done in reset", done, 0);
    chk(sclk == 1'(POL), "R3", "sclk in reset", sclk, POL);

    // Phase A: plain bring-up
    rst_n = 1'b1;
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    first_frame(); table_after_first(); match_groups();
    chk(busy == 1'b0, "R10", "idle after table", busy, 0);
    chk(contrast == 8'd183, "R7", "contrast after table", contrast, 183);

    // Phase B: request while idle
    pulse_req(8'h40);
    while (cs_n) @(negedge clk);
    chk(contrast == 8'd183, "R8", "contrast held mid-frame", contrast, 183);
    while (busy) @(negedge clk);
    ctr_frame(8'h40); match_groups();
    chk(contrast == 8'h40, "R8", "contrast after frame", contrast, 8'h40);
    chk(done == 1'b1, "R10", "done still high", done, 1);

    // Phase C: reset, then two requests inside the first frame
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(contrast == 8'd183, "R7", "contrast back to reset", contrast, 183);
    chk(done == 1'b0, "R10", "done cleared by reset", done, 0);
    obs.delete(); nbits = 0;
    rst_n = 1'b1;
    while (cs_n) @(negedge clk);
    repeat (10) @(negedge clk);
    pulse_req(8'h20);
    repeat (5) @(negedge clk);
    pulse_req(8'h5A);
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    first_frame(); ctr_frame(8'h5A); table_after_first(); match_groups();
    chk(contrast == 8'h5A, "R9", "last pending value kept", contrast, 8'h5A);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "WD", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule